// File: doc/BRIEF.md
# Match-Compare System Timer with Watchdog Channel

The block is a free-running 32-bit up-counter paired with four 32-bit compare registers. A one-cycle tick-enable input advances the counter. It stands in for a slow fixed-rate timer clock that is sampled in the system clock domain. On every tick, each compare register is checked against the value the counter takes at that edge. A hit latches a sticky status flag for that channel, and the status flags drive interrupt request lines toward an external interrupt controller. Software accesses every register through a simple word-addressed bus with single-cycle writes and combinational reads.

The highest channel (channel 3) has a second role. Once software sets a write-once guard bit, a hit on that channel no longer raises its interrupt line. It produces a one-cycle system reset request instead. The request also feeds back inside the block as a synchronous clear, so the counter, compare registers, status flags and guard bit all return to zero on the next edge. The guard bit can only be cleared by a hardware reset, a software reset pulse, sleep entry or that watchdog clear.

Register offsets (byte addresses, word aligned): compare 0..3 at 0x00, 0x04, 0x08, 0x0C; counter at 0x10; status at 0x14; watchdog guard at 0x18. Every other offset reads as zero.

Top module: `os_match_timer`

## Requirements
- R1: After `rst_n` is released, every readable register reads zero, `irq` is 0 and `wdt_reset` is 0.
- R2: A clock edge with `tick` high and no counter write adds one to the counter, and 0xFFFFFFFF wraps to 0. With `tick` low the counter holds its value.
- R3: A write to offset 0x10 loads the counter with `wdata` at that edge. A write wins over a tick in the same cycle, and the value reads back at 0x10.
- R4: Compare registers 0..3 at offsets 0x00, 0x04, 0x08, 0x0C are written with `wdata` and read back unchanged.
- R5: When a tick edge brings the counter to a value equal to compare register n, status bit n (offset 0x14, bit n) is set at that same edge and stays set across later ticks.
- R6: Writing offset 0x14 clears each status bit whose `wdata` bit is 1, and a 0 leaves that bit unchanged. If a hit and a clear of the same bit fall in one cycle, the bit ends up set.
- R7: `irq[n]` equals status bit n for n = 0..2. `irq[3]` equals status bit 3 while the watchdog guard is 0, and is 0 while the guard is 1.
- R8: Writing offset 0x18 with `wdata[0]`=1 sets the watchdog guard, and writing 0 leaves it unchanged. Offset 0x18 reads the guard in bit 0 and zero in bits 31..1.
- R9: With the guard set, a channel-3 hit at a tick edge makes `wdt_reset` high for exactly the next cycle. The edge ending that cycle clears the counter, all compare registers, the status flags and the guard.
- R10: A cycle with `soft_rst` high clears the counter, compare registers, status and guard at its edge. A cycle with `sleep_enter` high clears only the guard.
- R11: Reads of offsets not listed in the map (for example 0x1C) return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset pulse |
| sleep_enter | input | 1 | Sleep-entry pulse; clears the watchdog guard |
| tick | input | 1 | Timer advance enable, one cycle per timer period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 4 | Per-channel interrupt requests |
| wdt_reset | output | 1 | One-cycle system reset request from the watchdog |

## Verification
Compare hits are produced three ways: by ticking the counter onto a compare value from just below it, by loading the counter past a compare value (which must not hit because no tick compare happens), and by ticking onto it in the same cycle as a clear write. These separate a tick-qualified comparison from a level comparison and show the priority between a hit and a clear. Channel 3 is driven to a hit once with the guard clear and once with it set, which distinguishes interrupt routing from the reset path and checks the one-cycle width of the pulse and the full register clear it causes. The counter is also loaded at 0xFFFFFFFF and with a simultaneous tick, which exposes wrap handling and write priority.

// File: rtl/os_timer_pkg.sv
package os_timer_pkg;

  localparam int unsigned REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] OFS_COUNT  = 5'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 5'h14;
  localparam logic [REG_ADDR_W-1:0] OFS_GUARD  = 5'h18;

  typedef enum logic [2:0] {
    SEL_CMP,
    SEL_COUNT,
    SEL_STATUS,
    SEL_GUARD,
    SEL_NONE
  } reg_sel_e;

  // Compare register slot k sits at byte offset 4*k.
  function automatic logic [REG_ADDR_W-1:0] cmp_ofs(input int unsigned k);
    return REG_ADDR_W'(k * 4);
  endfunction

endpackage

// File: rtl/os_tmr_counter.sv
module os_tmr_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_inc
);

  logic [CW-1:0] cnt_d;

  assign cnt_inc = cnt_q + CW'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (ld)   cnt_d = ld_val;
    else if (tick) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/os_tmr_cmp_bank.sv
module os_tmr_cmp_bank #(
  parameter int unsigned CW  = 32,
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NCH-1:0] wr_sel,
  input  logic [CW-1:0]  wdata,
  input  logic           cmp_en,
  input  logic [CW-1:0]  cmp_val,
  output logic [CW-1:0]  cmp_q [NCH],
  output logic [NCH-1:0] hit
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cmp_d;

    always_comb begin
      cmp_d = cmp_q[i];
      if (clr)            cmp_d = '0;
      else if (wr_sel[i]) cmp_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[i] <= '0;
      else        cmp_q[i] <= cmp_d;
    end

    assign hit[i] = cmp_en && (cmp_q[i] == cmp_val);
  end

endmodule

// File: rtl/os_tmr_status.sv
module os_tmr_status #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           sleep_enter,
  input  logic [NCH-1:0] hit,
  input  logic           w1c_en,
  input  logic [NCH-1:0] w1c_mask,
  input  logic           guard_set,
  output logic [NCH-1:0] status_q,
  output logic           guard_q,
  output logic           wdt_q,
  output logic [NCH-1:0] irq
);

  localparam int unsigned WD_CH = NCH - 1;

  logic [NCH-1:0] status_d;
  logic           guard_d;
  logic           wdt_d;

  always_comb begin
    status_d = status_q;
    guard_d  = guard_q;
    wdt_d    = 1'b0;
    if (clr) begin
      status_d = '0;
      guard_d  = 1'b0;
    end else begin
      // Hits are ORed in after the clear mask so a same-cycle hit survives.
      if (w1c_en) status_d = status_d & ~w1c_mask;
      status_d = status_d | hit;
      if (sleep_enter)    guard_d = 1'b0;
      else if (guard_set) guard_d = 1'b1;
      wdt_d = hit[WD_CH] && guard_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      guard_q  <= 1'b0;
      wdt_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      guard_q  <= guard_d;
      wdt_q    <= wdt_d;
    end
  end

  always_comb begin
    irq        = status_q;
    irq[WD_CH] = status_q[WD_CH] && !guard_q;
  end

endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import os_timer_pkg::*;
#(
  parameter int unsigned CW  = 32,
  parameter int unsigned NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  sleep_enter,
  input  logic                  tick,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [CW-1:0]         wdata,
  output logic [CW-1:0]         rdata,
  output logic [NCH-1:0]        irq,
  output logic                  wdt_reset
);

  localparam int unsigned SEL_W = $clog2(NCH);

  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cnt_inc;
  logic [CW-1:0]  cmp_q [NCH];
  logic [NCH-1:0] hit;
  logic [NCH-1:0] status_q;
  logic           wden_q;
  logic           wdt_q;
  logic           sync_clr;
  logic           cnt_wr;
  logic           cmp_en;
  logic [NCH-1:0] cmp_wr;
  reg_sel_e       sel;
  logic [SEL_W-1:0] cmp_idx;

  assign sync_clr  = soft_rst || wdt_q;
  assign wdt_reset = wdt_q;

  // Address decode
  always_comb begin
    sel     = SEL_NONE;
    cmp_idx = '0;
    for (int k = 0; k < NCH; k++) begin
      if (addr == cmp_ofs(k)) begin
        sel     = SEL_CMP;
        cmp_idx = SEL_W'(k);
      end
    end
    if (addr == OFS_COUNT)  sel = SEL_COUNT;
    if (addr == OFS_STATUS) sel = SEL_STATUS;
    if (addr == OFS_GUARD)  sel = SEL_GUARD;
  end

  always_comb begin
    cmp_wr = '0;
    if (wr_en && sel == SEL_CMP) cmp_wr[cmp_idx] = 1'b1;
  end

  assign cnt_wr = wr_en && (sel == SEL_COUNT);
  assign cmp_en = tick && !cnt_wr && !sync_clr;

  os_tmr_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sync_clr),
    .tick   (tick),
    .ld     (cnt_wr),
    .ld_val (wdata),
    .cnt_q  (cnt_q),
    .cnt_inc(cnt_inc)
  );

  os_tmr_cmp_bank #(.CW(CW), .NCH(NCH)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sync_clr),
    .wr_sel (cmp_wr),
    .wdata  (wdata),
    .cmp_en (cmp_en),
    .cmp_val(cnt_inc),
    .cmp_q  (cmp_q),
    .hit    (hit)
  );

  os_tmr_status #(.NCH(NCH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (sync_clr),
    .sleep_enter(sleep_enter),
    .hit        (hit),
    .w1c_en     (wr_en && sel == SEL_STATUS),
    .w1c_mask   (wdata[NCH-1:0]),
    .guard_set  (wr_en && sel == SEL_GUARD && wdata[0]),
    .status_q   (status_q),
    .guard_q    (wden_q),
    .wdt_q      (wdt_q),
    .irq        (irq)
  );

  // Read mux
  always_comb begin
    unique case (sel)
      SEL_CMP:    rdata = cmp_q[cmp_idx];
      SEL_COUNT:  rdata = cnt_q;
      SEL_STATUS: rdata = {{(CW-NCH){1'b0}}, status_q};
      SEL_GUARD:  rdata = {{(CW-1){1'b0}}, wden_q};
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/os_timer_checker.sv
module os_timer_checker
  import os_timer_pkg::*;
#(
  parameter int unsigned CW  = 32,
  parameter int unsigned NCH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  soft_rst,
  input logic                  sleep_enter,
  input logic                  tick,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [NCH-1:0]        irq,
  input logic                  wdt_reset,
  input logic [CW-1:0]         cnt_q,
  input logic [NCH-1:0]        status_q,
  input logic                  wden_q
);

  logic cnt_wr_c;
  logic clr_c;
  assign cnt_wr_c = wr_en && (addr == OFS_COUNT);
  assign clr_c    = soft_rst || wdt_reset;

  p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr_c && !clr_c) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr_c && !clr_c) |=> $stable(cnt_q));

  p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_c && !(wr_en && addr == OFS_STATUS)) |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_irq3_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wden_q |-> !irq[NCH-1]);

  p_guard_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wden_q && !soft_rst && !sleep_enter && !wdt_reset) |=> wden_q);

  p_wdt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  p_wdt_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> (cnt_q == '0 && status_q == '0 && !wden_q));

  p_sleep_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> !wden_q);

endmodule

bind os_match_timer os_timer_checker #(.CW(CW), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .sleep_enter(sleep_enter),
  .tick       (tick),
  .wr_en      (wr_en),
  .addr       (addr),
  .irq        (irq),
  .wdt_reset  (wdt_reset),
  .cnt_q      (cnt_q),
  .status_q   (status_q),
  .wden_q     (wden_q)
);

// File: tb/sim_os_match_timer.sv
`timescale 1ns/1ps
module sim_os_match_timer;

  logic        clk;
  logic        rst_n;
  logic        soft_rst;
  logic        sleep_enter;
  logic        tick;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        wdt_reset;

  int checks;
  int failures;

  os_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sleep_enter(sleep_enter),
    .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .wdt_reset(wdt_reset)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic t = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), d);
      check("R1 reg after reset", d, 32'h0);
    end
    check("R1 irq after reset", {28'h0, irq}, 32'h0);
    check("R1 wdt_reset after reset", {31'h0, wdt_reset}, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(5'h10, 32'd100);
    rd(5'h10, d); check("R3 counter load", d, 32'd100);
    do_tick(3);
    rd(5'h10, d); check("R2 three ticks", d, 32'd103);
    repeat (5) @(negedge clk);
    rd(5'h10, d); check("R2 hold without tick", d, 32'd103);
    wr(5'h10, 32'hFFFF_FFFF);
    do_tick(1);
    rd(5'h10, d); check("R2 wrap to zero", d, 32'h0);
    wr(5'h10, 32'd50, 1'b1);
    rd(5'h10, d); check("R3 write beats tick", d, 32'd50);
  endtask

  task automatic t_cmp_regs();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) wr(5'(k * 4), 32'hA5A0_0000 + 32'(k * 1000) + 32'd7);
    for (int k = 0; k < 4; k++) begin
      rd(5'(k * 4), d);
      check("R4 compare readback", d, 32'hA5A0_0000 + 32'(k * 1000) + 32'd7);
    end
    rd(5'h1C, d); check("R11 unused offset 0x1C", d, 32'h0);
    rd(5'h1E, d); check("R11 unused offset 0x1E", d, 32'h0);
  endtask

  task automatic t_match();
    logic [31:0] d;
    wr(5'h14, 32'hF);
    wr(5'h04, 32'd10);
    wr(5'h10, 32'd8);
    do_tick(1);
    rd(5'h14, d); check("R5 no hit before match", {31'h0, d[1]}, 32'h0);
    do_tick(1);
    rd(5'h14, d); check("R5 hit sets bit1", {31'h0, d[1]}, 32'h1);
    check("R7 irq1 follows status", {31'h0, irq[1]}, 32'h1);
    do_tick(4);
    rd(5'h14, d); check("R5 bit1 sticky", {31'h0, d[1]}, 32'h1);
    // Loading past a compare value is not a tick compare.
    wr(5'h14, 32'h2);
    wr(5'h10, 32'd10);
    rd(5'h14, d); check("R5 load does not hit", {31'h0, d[1]}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(5'h04, 32'd40);
    wr(5'h10, 32'd39);
    do_tick(1);
    wr(5'h14, 32'h0);
    rd(5'h14, d); check("R6 write zero keeps bit", {31'h0, d[1]}, 32'h1);
    wr(5'h14, 32'h2);
    rd(5'h14, d); check("R6 write one clears bit", {31'h0, d[1]}, 32'h0);
    check("R7 irq1 drops with status", {31'h0, irq[1]}, 32'h0);
    wr(5'h00, 32'd20);
    wr(5'h10, 32'd19);
    wr(5'h14, 32'h1, 1'b1);
    rd(5'h14, d); check("R6 hit beats clear", {31'h0, d[0]}, 32'h1);
    wr(5'h14, 32'hF);
  endtask

  task automatic t_guard();
    logic [31:0] d;
    rd(5'h18, d); check("R8 guard initially clear", d, 32'h0);
    wr(5'h0C, 32'd30);
    wr(5'h10, 32'd29);
    do_tick(1);
    check("R7 irq3 when guard clear", {31'h0, irq[3]}, 32'h1);
    check("R7 no reset when guard clear", {31'h0, wdt_reset}, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, d); check("R8 guard set, upper zero", d, 32'h1);
    check("R7 irq3 masked by guard", {31'h0, irq[3]}, 32'h0);
    wr(5'h18, 32'h0);
    rd(5'h18, d); check("R8 write zero ignored", d, 32'h1);
    wr(5'h14, 32'hF);
  endtask

  task automatic t_watchdog();
    logic [31:0] d;
    wr(5'h0C, 32'd500);
    wr(5'h10, 32'd499);
    do_tick(1);
    #1;
    check("R9 reset pulse asserted", {31'h0, wdt_reset}, 32'h1);
    check("R7 irq3 silent in watchdog mode", {31'h0, irq[3]}, 32'h0);
    @(negedge clk);
    #1;
    check("R9 pulse lasts one cycle", {31'h0, wdt_reset}, 32'h0);
    rd(5'h10, d); check("R9 counter cleared", d, 32'h0);
    rd(5'h0C, d); check("R9 compare3 cleared", d, 32'h0);
    rd(5'h04, d); check("R9 compare1 cleared", d, 32'h0);
    rd(5'h14, d); check("R9 status cleared", d, 32'h0);
    rd(5'h18, d); check("R9 guard cleared", d, 32'h0);
  endtask

  task automatic t_soft_sleep();
    logic [31:0] d;
    wr(5'h18, 32'h1);
    wr(5'h10, 32'd7);
    wr(5'h08, 32'd77);
    @(negedge clk); sleep_enter = 1'b1;
    @(negedge clk); sleep_enter = 1'b0;
    rd(5'h18, d); check("R10 sleep clears guard", d, 32'h0);
    rd(5'h10, d); check("R10 sleep keeps counter", d, 32'd7);
    rd(5'h08, d); check("R10 sleep keeps compare", d, 32'd77);
    wr(5'h18, 32'h1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(5'h18, d); check("R10 soft reset clears guard", d, 32'h0);
    rd(5'h10, d); check("R10 soft reset clears counter", d, 32'h0);
    rd(5'h08, d); check("R10 soft reset clears compare", d, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; soft_rst = 1'b0; sleep_enter = 1'b0;
    tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_cmp_regs();
    t_match();
    t_w1c();
    t_guard();
    t_watchdog();
    t_soft_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule